// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

The block sits between a processor request port and a slower memory behind it. It holds four lines of 32-byte blocks, each with a tag and a valid flag. A 32-bit byte address is divided into a tag (bits 31:7), a line index (bits 6:5) and a byte offset (bits 4:0). Bits 4:2 of the offset pick one 32-bit word inside the block.

The processor raises `cpu_req_i` for one cycle while the controller is idle. The controller captures the address, the direction and the write data, then holds `cpu_wait_o` high while it compares tags. A read that hits finishes after the compare. A read that misses first fetches the whole block from memory and replaces the line at that index. Writes follow a write-through, no-allocate policy. The tag is compared before the data array is changed, and only a hit changes a cached word. Every write then goes to memory as a single-word transfer. The access finishes in the cycle where `cpu_wait_o` falls, and read data is valid on `cpu_rdata_o` in that cycle.

The memory side uses a request/acknowledge handshake. `mem_req_o` stays high until `mem_ack_i` arrives. For a block fetch, the whole block is presented on `mem_rdata_i` in the acknowledge cycle.

Top module: `dm_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first read to each of the four indices misses and issues a memory fetch.
- R2: A request seen while idle is captured at that clock edge. `cpu_wait_o` is high in the following cycle. A read hit drops `cpu_wait_o` one cycle later, with the addressed word (selected by bits 4:2) on `cpu_rdata_o`.
- R3: A hit needs the line at index bits 6:5 to be valid and its stored tag to equal address bits 31:7. An address with the same index but a different tag misses.
- R4: A read miss raises `mem_req_o` with `mem_we_o` low and `mem_addr_o` equal to the address with bits 4:0 cleared. This happens in the cycle after the tag compare.
- R5: In the acknowledge cycle of a fetch, the block on `mem_rdata_i` is installed in the indexed line, replacing the old line. Word k sits at bits 32k+31:32k. The next cycle drops `cpu_wait_o` and shows the requested word on `cpu_rdata_o`.
- R6: A write that hits updates the cached word, so a later read of it hits and returns the new data.
- R7: A write that misses does not allocate. A later read of that address misses, and the line already at that index stays resident.
- R8: Every write, hit or miss, raises `mem_req_o` with `mem_we_o` high, the full byte address on `mem_addr_o` and the data on `mem_wdata_o`. `cpu_wait_o` stays high until the acknowledge and drops in the next cycle.
- R9: A request raised while an access is in progress is ignored. No further transfer starts and the cache contents are not changed.
- R10: Once raised, `mem_req_o`, `mem_addr_o` and `mem_we_o` hold steady until `mem_ack_i`.
- R11: `mem_req_o` is high only while `cpu_wait_o` is high. When no access is in progress, `cpu_wait_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request, sampled while idle |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write data |
| cpu_wait_o | output | 1 | Access in progress |
| cpu_rdata_o | output | 32 | Read data, valid when wait falls after a read |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Memory transfer is a word write |
| mem_addr_o | output | 32 | Block address (fetch) or byte address (write) |
| mem_wdata_o | output | 32 | Write-through data |
| mem_ack_i | input | 1 | Memory transfer complete |
| mem_rdata_i | input | 256 | Fetched block, word k at bits 32k+31:32k |

## Verification
The assertions check the memory-side handshake on every cycle. The request, address and direction must hold until acknowledge. A memory request may only appear while the processor is stalled. A fetch must use a block-aligned address. Each acknowledge must end the stall one cycle later, and a fetch must return the selected word of the acknowledged block. Cache state cannot be seen at the ports on any single cycle, so the bench scenarios cover the rest. These include the hit and miss decisions, line replacement, write-hit updates, the absence of write allocation, and ignored requests during a busy access. For each of these, the bench compares the stall length, the memory traffic and the returned data with a behavioural model.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG_CHECK,
    ST_MISS_FETCH,
    ST_WRITE_THROUGH,
    ST_RESPOND
  } ctrl_state_e;
endpackage

// File: rtl/dm_cache_tag_store.sv
module dm_cache_tag_store #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 25,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] look_idx_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             hit_o,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [TAG_W-1:0] set_tag_i
);
  logic [LINES-1:0]       valid_flat;
  logic [LINES*TAG_W-1:0] tag_flat;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
      end else if (set_en_i && set_idx_i == IDX_W'(l)) begin
        valid_q <= 1'b1;
        tag_q   <= set_tag_i;
      end
    end
    assign valid_flat[l]                  = valid_q;
    assign tag_flat[l*TAG_W +: TAG_W]     = tag_q;
  end

  logic [TAG_W-1:0] look_tag_stored;
  assign look_tag_stored = tag_flat[int'(look_idx_i)*TAG_W +: TAG_W];
  assign hit_o = valid_flat[look_idx_i] && (look_tag_stored == look_tag_i);
endmodule

// File: rtl/dm_cache_data_store.sv
module dm_cache_data_store #(
  parameter int IDX_W  = 2,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W,
  localparam int WORDS = 1 << SEL_W,
  localparam int BLK_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_word_o,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [BLK_W-1:0]  fill_blk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [LINES*BLK_W-1:0] store_flat;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk_i) begin
        if (fill_en_i && fill_idx_i == IDX_W'(l))
          word_q <= fill_blk_i[w*DATA_W +: DATA_W];
        else if (wr_en_i && wr_idx_i == IDX_W'(l) && wr_sel_i == SEL_W'(w))
          word_q <= wr_data_i;
      end
      assign store_flat[(l*WORDS+w)*DATA_W +: DATA_W] = word_q;
    end
  end

  logic [IDX_W+SEL_W-1:0] rd_slot;
  assign rd_slot   = {rd_idx_i, rd_sel_i};
  assign rd_word_o = store_flat[int'(rd_slot)*DATA_W +: DATA_W];
endmodule

// File: rtl/dm_cache_fsm.sv
module dm_cache_fsm
  import dm_cache_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_q_i,
  input  logic        hit_i,
  input  logic        mem_ack_i,
  output ctrl_state_e state_o,
  output logic        accept_o
);
  ctrl_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:          if (req_i) state_d = ST_TAG_CHECK;
      ST_TAG_CHECK:     state_d = we_q_i ? ST_WRITE_THROUGH
                                         : (hit_i ? ST_RESPOND : ST_MISS_FETCH);
      ST_MISS_FETCH:    if (mem_ack_i) state_d = ST_RESPOND;
      ST_WRITE_THROUGH: if (mem_ack_i) state_d = ST_RESPOND;
      ST_RESPOND:       state_d = ST_IDLE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 5,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int SEL_W  = OFF_W - BYTE_W,
  localparam int BLK_W  = (1 << SEL_W) * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_wait_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [BLK_W-1:0]  mem_rdata_i
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  ctrl_state_e state;
  logic        accept;
  logic        hit;

  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0]  addr_tag;
  logic [IDX_W-1:0]  addr_idx;
  logic [SEL_W-1:0]  addr_sel;
  logic [DATA_W-1:0] cached_word;
  logic              fill_en;
  logic              word_wr_en;

  assign addr_tag = addr_q[ADDR_W-1 -: TAG_W];
  assign addr_idx = addr_q[OFF_W +: IDX_W];
  assign addr_sel = addr_q[BYTE_W +: SEL_W];

  dm_cache_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (cpu_req_i),
    .we_q_i    (we_q),
    .hit_i     (hit),
    .mem_ack_i (mem_ack_i),
    .state_o   (state),
    .accept_o  (accept)
  );

  // capture the request only when the controller is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= cpu_addr_i;
      we_q    <= cpu_we_i;
      wdata_q <= cpu_wdata_i;
    end
  end

  assign fill_en    = (state == ST_MISS_FETCH) && mem_ack_i;
  // data array written only after the tag compare confirms a hit
  assign word_wr_en = (state == ST_TAG_CHECK) && we_q && hit;

  dm_cache_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_idx_i (addr_idx),
    .look_tag_i (addr_tag),
    .hit_o      (hit),
    .set_en_i   (fill_en),
    .set_idx_i  (addr_idx),
    .set_tag_i  (addr_tag)
  );

  dm_cache_data_store #(
    .IDX_W  (IDX_W),
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk_i      (clk_i),
    .rd_idx_i   (addr_idx),
    .rd_sel_i   (addr_sel),
    .rd_word_o  (cached_word),
    .fill_en_i  (fill_en),
    .fill_idx_i (addr_idx),
    .fill_blk_i (mem_rdata_i),
    .wr_en_i    (word_wr_en),
    .wr_idx_i   (addr_idx),
    .wr_sel_i   (addr_sel),
    .wr_data_i  (wdata_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (state == ST_TAG_CHECK && !we_q && hit) begin
      rdata_q <= cached_word;
    end else if (fill_en) begin
      rdata_q <= mem_rdata_i[int'(addr_sel)*DATA_W +: DATA_W];
    end
  end

  assign cpu_rdata_o = rdata_q;
  assign cpu_wait_o  = (state == ST_TAG_CHECK) || (state == ST_MISS_FETCH) ||
                       (state == ST_WRITE_THROUGH);
  assign mem_req_o   = (state == ST_MISS_FETCH) || (state == ST_WRITE_THROUGH);
  assign mem_we_o    = (state == ST_WRITE_THROUGH);
  assign mem_addr_o  = mem_we_o ? addr_q : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/dm_cache_ctrl_sva.sv
module dm_cache_ctrl_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 5,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int SEL_W  = OFF_W - BYTE_W,
  localparam int BLK_W  = (1 << SEL_W) * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_wait_o,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic [BLK_W-1:0]  mem_rdata_i,
  input logic [ADDR_W-1:0] addr_q_i
);
  logic [DATA_W-1:0] picked_word;
  assign picked_word = mem_rdata_i[int'(addr_q_i[BYTE_W +: SEL_W])*DATA_W +: DATA_W];

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o);

  p_req_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(mem_addr_o) && $stable(mem_we_o));

  p_req_only_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> cpu_wait_o);

  p_fetch_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o[OFF_W-1:0] == '0);

  p_ack_ends_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !cpu_wait_o);

  p_fill_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i |=> cpu_rdata_o == $past(picked_word));
endmodule

bind dm_cache_ctrl dm_cache_ctrl_sva #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .OFF_W  (OFF_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_wait_o  (cpu_wait_o),
  .cpu_rdata_o (cpu_rdata_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .mem_rdata_i (mem_rdata_i),
  .addr_q_i    (addr_q)
);

// File: tb/dm_cache_ctrl_tb.sv
module dm_cache_ctrl_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cpu_req_i = 1'b0;
  logic         cpu_we_i = 1'b0;
  logic [31:0]  cpu_addr_i = '0;
  logic [31:0]  cpu_wdata_i = '0;
  logic         cpu_wait_o;
  logic [31:0]  cpu_rdata_o;
  logic         mem_req_o;
  logic         mem_we_o;
  logic [31:0]  mem_addr_o;
  logic [31:0]  mem_wdata_o;
  logic         mem_ack_i = 1'b0;
  logic [255:0] mem_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dm_cache_ctrl u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_wait_o  (cpu_wait_o),
    .cpu_rdata_o (cpu_rdata_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i)
  );

  // behavioural reference: line state and backing memory
  bit          m_valid [4];
  logic [24:0] m_tag   [4];
  logic [31:0] m_mem   [int];

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    int key = int'(a >> 2);
    if (m_mem.exists(key)) return m_mem[key];
    return ((a & 32'hFFFF_FFFC) * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [255:0] blk_of(logic [31:0] a);
    logic [255:0] b;
    for (int w = 0; w < 8; w++)
      b[w*32 +: 32] = mem_rd({a[31:5], 5'(w * 4)});
    return b;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // one access, starting and ending at a negedge with the controller idle
  task automatic access(bit we, logic [31:0] a, logic [31:0] d, int lat,
                        bit poke, logic [31:0] poke_a);
    int  idx = int'(a[6:5]);
    bit  hit = m_valid[idx] && (m_tag[idx] == a[31:7]);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk_i);
    cpu_req_i = 1'b0; cpu_we_i = 1'b0; cpu_addr_i = '0; cpu_wdata_i = '0;
    chk(cpu_wait_o == 1'b1, "R2", "wait after accept", 32'(cpu_wait_o), 1);
    chk(mem_req_o == 1'b0, "R11", "no mem req during compare", 32'(mem_req_o), 0);
    @(negedge clk_i);
    if (!we && hit) begin
      chk(cpu_wait_o == 1'b0, "R3", "read hit completes", 32'(cpu_wait_o), 0);
      chk(cpu_rdata_o == mem_rd(a), "R2", "read hit data", cpu_rdata_o, mem_rd(a));
    end else begin
      chk(mem_req_o == 1'b1, we ? "R8" : "R4", "mem req raised", 32'(mem_req_o), 1);
      chk(mem_we_o == we, we ? "R8" : "R4", "mem direction", 32'(mem_we_o), 32'(we));
      chk(mem_addr_o == (we ? a : {a[31:5], 5'd0}), we ? "R8" : "R4", "mem addr",
          mem_addr_o, we ? a : {a[31:5], 5'd0});
      if (we) chk(mem_wdata_o == d, "R8", "mem wdata", mem_wdata_o, d);
      for (int i = 0; i < lat; i++) begin
        if (poke && i == 0) begin
          cpu_req_i = 1'b1; cpu_we_i = 1'b1; cpu_addr_i = poke_a; cpu_wdata_i = 32'hDEAD_BEEF;
        end
        @(negedge clk_i);
        chk(mem_req_o == 1'b1 && cpu_wait_o == 1'b1, "R10", "req held until ack",
            {mem_req_o, cpu_wait_o}, 2'b11);
        chk(mem_addr_o == (we ? a : {a[31:5], 5'd0}), "R10", "addr held",
            mem_addr_o, we ? a : {a[31:5], 5'd0});
      end
      cpu_req_i = 1'b0; cpu_we_i = 1'b0; cpu_addr_i = '0; cpu_wdata_i = '0;
      mem_ack_i = 1'b1;
      mem_rdata_i = we ? 256'(0) : blk_of(a);
      @(negedge clk_i);
      mem_ack_i = 1'b0;
      mem_rdata_i = '0;
      chk(cpu_wait_o == 1'b0, we ? "R8" : "R5", "wait drops after ack", 32'(cpu_wait_o), 0);
      if (!we) chk(cpu_rdata_o == mem_rd(a), "R5", "fill data", cpu_rdata_o, mem_rd(a));
    end
    if (we) m_mem[int'(a >> 2)] = d;
    else if (!hit) begin
      m_valid[idx] = 1'b1;
      m_tag[idx]   = a[31:7];
    end
    @(negedge clk_i);
    chk(cpu_wait_o == 1'b0 && mem_req_o == 1'b0, poke ? "R9" : "R11", "idle after access",
        {cpu_wait_o, mem_req_o}, 0);
  endtask

  task automatic expect_miss(bit exp_miss, logic [31:0] a, string req);
    int  idx = int'(a[6:5]);
    bit  hit = m_valid[idx] && (m_tag[idx] == a[31:7]);
    chk(hit == !exp_miss, req, "model hit prediction", 32'(hit), 32'(!exp_miss));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
    repeat (3) @(negedge clk_i);
    chk(cpu_wait_o == 1'b0 && mem_req_o == 1'b0, "R11", "reset outputs",
        {cpu_wait_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: cold misses on every index, varied latency
    for (int l = 0; l < 4; l++) begin
      expect_miss(1'b1, 32'h1000_0000 | (l << 5) | (l * 4), "R1");
      access(1'b0, 32'h1000_0000 | (l << 5) | (l * 4), '0, l, 1'b0, '0);
    end
    // R2 R3: hits on other words of resident lines
    for (int l = 0; l < 4; l++)
      access(1'b0, 32'h1000_0000 | (l << 5) | (28 - l * 4), '0, 0, 1'b0, '0);
    // R3 R5: same index, different tag replaces the line
    expect_miss(1'b1, 32'h2000_0048, "R3");
    access(1'b0, 32'h2000_0048, '0, 1, 1'b0, '0);
    access(1'b0, 32'h2000_0044, '0, 0, 1'b0, '0);
    expect_miss(1'b1, 32'h1000_0040, "R5");
    access(1'b0, 32'h1000_0040, '0, 2, 1'b0, '0);
    // R6: write hit then read back
    access(1'b1, 32'h1000_0024, 32'hCAFE_0001, 2, 1'b0, '0);
    access(1'b0, 32'h1000_0024, '0, 0, 1'b0, '0);
    // R7: write miss does not allocate, resident line kept
    access(1'b1, 32'h3000_0060, 32'h0BAD_F00D, 0, 1'b0, '0);
    expect_miss(1'b0, 32'h1000_0064, "R7");
    access(1'b0, 32'h1000_0064, '0, 0, 1'b0, '0);
    expect_miss(1'b1, 32'h3000_0060, "R7");
    access(1'b0, 32'h3000_0060, '0, 1, 1'b0, '0);
    // R9: request during busy fetch ignored; line 0 must stay intact
    access(1'b0, 32'h4000_0010, '0, 3, 1'b1, 32'h4000_0000);
    access(1'b0, 32'h4000_0000, '0, 0, 1'b0, '0);
    access(1'b0, 32'h1000_0024, '0, 0, 1'b0, '0);
    // R8: write with long latency, then hit read of it
    access(1'b1, 32'h4000_001C, 32'h1234_5678, 3, 1'b0, '0);
    access(1'b0, 32'h4000_001C, '0, 0, 1'b0, '0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule